// File: doc/BRIEF.md
# Queue Occupancy Statistics Monitor

This block is a bank of independent monitor channels. Each channel is programmed to observe one hardware queue. A shared activity stream reports every push and pop: it carries the queue index, the direction and the element count the queue held when the operation was made. A channel that matches the queue index gathers statistics according to its mode. It can count pushes and pops, check the count against a software window, track the lowest and highest counts seen, or count pops made against an empty queue.

Software reaches each channel through four 32-bit words in a register window of 0x1000 bytes. The words are a control word (event number, source select and mode), a queue select word and two data words. The meaning of the data words, and whether software may write them, follows the current mode. In threshold mode a channel raises a one-cycle event carrying its programmed event number when the count leaves the window. When several channels raise an event in the same cycle, a single event output carries the number of the lowest-numbered one.

Top module: `qmon_top`

## Requirements
- R1: After reset every control word reads 0xFFFF0000, and every queue select word and data word reads 0. The event output is low.
- R2: In mode 1 (control bits 2:0 = 1), each matching push adds one to data word 0 and each matching pop adds one to data word 1. A write from software to either data word is ignored.
- R3: A channel ignores activity whose queue index differs from its queue select word (bits 15:0). It also ignores all activity when its source select (control bits 11:8) is nonzero, or when its mode is 0, 5, 6 or 7.
- R4: In mode 2 software may write data word 0 (the low threshold) and data word 1 (the high threshold) and read them back. In every other mode, writes to the data words have no effect.
- R5: In mode 3, data word 0 holds the lowest count seen since the mode was entered and data word 1 holds the highest.
- R6: In mode 2 a channel tracks whether the count lies inside the window low <= count <= high, and treats itself as inside on mode entry. When a matching operation reports a count outside the window while the channel was inside, evt_valid is high for one cycle after that operation, with evt_num equal to control bits 31:16. No event is raised while the count stays outside the window, or in any other mode.
- R7: In mode 4, data word 0 counts matching pops that report a count of 0. Pushes, and pops with a nonzero count, leave it unchanged, and data word 1 reads 0.
- R8: Push, pop and starvation counters stop at 2^CTR_W-1 and do not wrap.
- R9: Any write to a control word reinitialises the channel's data words: to 0xFFFFFFFF (word 0) and 0 (word 1) when the new mode is 3, and to 0 for every other mode.
- R10: When more than one channel raises an event in the same cycle, evt_num carries the number of the lowest-indexed channel among them.
- R11: Channel n's words sit at byte address n*0x1000 plus 0x0 (control), 0x4 (queue select), 0x8 (data 0) and 0xC (data 1). Reserved control bits 15:12 and 7:3, and queue select bits 31:16, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 17 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| ev_valid | input | 1 | Queue operation valid |
| ev_push | input | 1 | 1 = push, 0 = pop |
| ev_queue | input | 16 | Index of the queue operated on |
| ev_count | input | COUNT_W | Element count held when the operation was made |
| evt_valid | output | 1 | Event pulse, one cycle after the triggering operation |
| evt_num | output | 16 | Event number of the winning channel |

## Verification
Each mode is exercised with count sweeps. For thresholds and watermarks the sweep runs up and back down across the window, so the expected minimum, maximum and crossing points follow directly from the sequence. Activity for a neighbouring queue is interleaved with matching activity. This separates a correct queue compare from one that counts everything, and channels with a nonzero source or a reserved mode separate correct gating from a plain mode decode. Streams of pushes, pops and starvation pops longer than the counter range separate saturation from wrap-around. Two threshold channels firing together, and then only one of them, separate priority by index from any other choice.

// File: rtl/qmon_pkg.sv
package qmon_pkg;
  localparam int WORD_W  = 32;
  localparam int QIDX_W  = 16;
  localparam int EVNUM_W = 16;
  localparam int ADDR_W  = 17;

  localparam logic [2:0] MODE_OFF    = 3'd0;
  localparam logic [2:0] MODE_STATS  = 3'd1;
  localparam logic [2:0] MODE_THRESH = 3'd2;
  localparam logic [2:0] MODE_WMARK  = 3'd3;
  localparam logic [2:0] MODE_STARVE = 3'd4;

  localparam logic [1:0] WSEL_CTL  = 2'd0;
  localparam logic [1:0] WSEL_QSEL = 2'd1;
  localparam logic [1:0] WSEL_LO   = 2'd2;
  localparam logic [1:0] WSEL_HI   = 2'd3;

  function automatic logic [WORD_W-1:0] sat_inc(input logic [WORD_W-1:0] v,
                                                input logic [WORD_W-1:0] lim);
    return (v >= lim) ? v : v + 1'b1;
  endfunction
endpackage

// File: rtl/qmon_regdec.sv
module qmon_regdec
  import qmon_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic [NUM_CH-1:0] ctl_we,
  output logic [NUM_CH-1:0] qsel_we,
  output logic [NUM_CH-1:0] lo_we,
  output logic [NUM_CH-1:0] hi_we,
  output logic [NUM_CH-1:0] rd_sel,
  output logic [1:0]        rd_word
);
  logic [4:0] ch_idx;
  logic       aligned;

  assign ch_idx  = reg_addr[16:12];
  assign rd_word = reg_addr[3:2];
  assign aligned = (reg_addr[11:4] == 8'd0) && (reg_addr[1:0] == 2'd0);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    logic hit;
    assign hit        = aligned && (ch_idx == 5'(g));
    assign rd_sel[g]  = hit;
    assign ctl_we[g]  = reg_wr && hit && (rd_word == WSEL_CTL);
    assign qsel_we[g] = reg_wr && hit && (rd_word == WSEL_QSEL);
    assign lo_we[g]   = reg_wr && hit && (rd_word == WSEL_LO);
    assign hi_we[g]   = reg_wr && hit && (rd_word == WSEL_HI);
  end
endmodule

// File: rtl/qmon_channel.sv
module qmon_channel
  import qmon_pkg::*;
#(
  parameter int CTR_W   = 32,
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic               qsel_we,
  input  logic               lo_we,
  input  logic               hi_we,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               ev_valid,
  input  logic               ev_push,
  input  logic [QIDX_W-1:0]  ev_queue,
  input  logic [COUNT_W-1:0] ev_count,
  output logic [WORD_W-1:0]  ctl_rd,
  output logic [WORD_W-1:0]  qsel_rd,
  output logic [WORD_W-1:0]  lo_rd,
  output logic [WORD_W-1:0]  hi_rd,
  output logic [2:0]         mode,
  output logic [EVNUM_W-1:0] evnum,
  output logic               fire
);
  localparam logic [WORD_W-1:0] CTR_MAX = WORD_W'((64'd1 << CTR_W) - 64'd1);

  logic [EVNUM_W-1:0] evnum_q, evnum_d;
  logic [3:0]         src_q, src_d;
  logic [2:0]         mode_q, mode_d;
  logic [QIDX_W-1:0]  qsel_q, qsel_d;
  logic [WORD_W-1:0]  lo_q, lo_d, hi_q, hi_d;
  logic               inside_q, inside_d;
  logic               cfg_en, data_en, match, now_in;
  logic [WORD_W-1:0]  cnt;
  logic               unused_wbits;

  assign unused_wbits = ^{wdata[15:12], wdata[7:3]};
  assign cnt     = WORD_W'(ev_count);
  assign match   = ev_valid && (src_q == 4'd0) && (ev_queue == qsel_q);
  assign now_in  = (cnt >= lo_q) && (cnt <= hi_q);
  assign cfg_en  = ctl_we;
  assign data_en = ctl_we || lo_we || hi_we || match;

  always_comb begin
    evnum_d  = evnum_q;
    src_d    = src_q;
    mode_d   = mode_q;
    qsel_d   = qsel_q;
    lo_d     = lo_q;
    hi_d     = hi_q;
    inside_d = inside_q;
    fire     = 1'b0;
    if (qsel_we) qsel_d = wdata[QIDX_W-1:0];
    if (ctl_we) begin
      evnum_d  = wdata[31:16];
      src_d    = wdata[11:8];
      mode_d   = wdata[2:0];
      inside_d = 1'b1;
      lo_d     = (wdata[2:0] == MODE_WMARK) ? '1 : '0;
      hi_d     = '0;
    end else begin
      if (mode_q == MODE_THRESH) begin
        if (lo_we) lo_d = wdata;
        if (hi_we) hi_d = wdata;
      end
      if (match) begin
        case (mode_q)
          MODE_STATS: begin
            if (ev_push) lo_d = sat_inc(lo_q, CTR_MAX);
            else         hi_d = sat_inc(hi_q, CTR_MAX);
          end
          MODE_THRESH: begin
            fire     = inside_q && !now_in;
            inside_d = now_in;
          end
          MODE_WMARK: begin
            if (cnt < lo_q) lo_d = cnt;
            if (cnt > hi_q) hi_d = cnt;
          end
          MODE_STARVE: begin
            if (!ev_push && (ev_count == '0)) lo_d = sat_inc(lo_q, CTR_MAX);
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evnum_q  <= '1;
      src_q    <= '0;
      mode_q   <= MODE_OFF;
      qsel_q   <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      inside_q <= 1'b1;
    end else begin
      if (cfg_en) begin
        evnum_q <= evnum_d;
        src_q   <= src_d;
        mode_q  <= mode_d;
      end
      if (qsel_we) qsel_q <= qsel_d;
      if (data_en) begin
        lo_q     <= lo_d;
        hi_q     <= hi_d;
        inside_q <= inside_d;
      end
    end
  end

  assign ctl_rd  = {evnum_q, 4'b0, src_q, 5'b0, mode_q};
  assign qsel_rd = {{(WORD_W-QIDX_W){1'b0}}, qsel_q};
  assign lo_rd   = lo_q;
  assign hi_rd   = hi_q;
  assign mode    = mode_q;
  assign evnum   = evnum_q;
endmodule

// File: rtl/qmon_evt_arb.sv
module qmon_evt_arb
  import qmon_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_CH-1:0]               fire,
  input  logic [NUM_CH-1:0][EVNUM_W-1:0]  evnum,
  output logic                            evt_valid,
  output logic [EVNUM_W-1:0]              evt_num
);
  logic               any_d, valid_q;
  logic [EVNUM_W-1:0] num_d, num_q;

  always_comb begin
    any_d = |fire;
    num_d = num_q;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (fire[i]) num_d = evnum[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      num_q   <= '0;
    end else begin
      valid_q <= any_d;
      if (any_d) num_q <= num_d;
    end
  end

  assign evt_valid = valid_q;
  assign evt_num   = num_q;
endmodule

// File: rtl/qmon_top.sv
module qmon_top
  import qmon_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int CTR_W   = 32,
  parameter int COUNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [16:0]         reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                ev_valid,
  input  logic                ev_push,
  input  logic [15:0]         ev_queue,
  input  logic [COUNT_W-1:0]  ev_count,
  output logic                evt_valid,
  output logic [15:0]         evt_num
);
  logic                            rst_meta, rst_ns;
  logic [NUM_CH-1:0]               ctl_we, qsel_we, lo_we, hi_we, rd_sel, fire;
  logic [1:0]                      rd_word;
  logic [NUM_CH-1:0][WORD_W-1:0]   ch_ctl, ch_qsel, ch_lo, ch_hi;
  logic [NUM_CH-1:0][2:0]          ch_mode;
  logic [NUM_CH-1:0][EVNUM_W-1:0]  ch_evnum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  qmon_regdec #(.NUM_CH(NUM_CH)) u_dec (
    .reg_wr  (reg_wr),
    .reg_addr(reg_addr),
    .ctl_we  (ctl_we),
    .qsel_we (qsel_we),
    .lo_we   (lo_we),
    .hi_we   (hi_we),
    .rd_sel  (rd_sel),
    .rd_word (rd_word)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    qmon_channel #(.CTR_W(CTR_W), .COUNT_W(COUNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_ns),
      .ctl_we  (ctl_we[g]),
      .qsel_we (qsel_we[g]),
      .lo_we   (lo_we[g]),
      .hi_we   (hi_we[g]),
      .wdata   (reg_wdata),
      .ev_valid(ev_valid),
      .ev_push (ev_push),
      .ev_queue(ev_queue),
      .ev_count(ev_count),
      .ctl_rd  (ch_ctl[g]),
      .qsel_rd (ch_qsel[g]),
      .lo_rd   (ch_lo[g]),
      .hi_rd   (ch_hi[g]),
      .mode    (ch_mode[g]),
      .evnum   (ch_evnum[g]),
      .fire    (fire[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_sel[i]) begin
        case (rd_word)
          WSEL_CTL:  reg_rdata = ch_ctl[i];
          WSEL_QSEL: reg_rdata = ch_qsel[i];
          WSEL_LO:   reg_rdata = ch_lo[i];
          default:   reg_rdata = ch_hi[i];
        endcase
      end
    end
  end

  qmon_evt_arb #(.NUM_CH(NUM_CH)) u_arb (
    .clk      (clk),
    .rst_n    (rst_ns),
    .fire     (fire),
    .evnum    (ch_evnum),
    .evt_valid(evt_valid),
    .evt_num  (evt_num)
  );
endmodule

// File: rtl/qmon_sva.sv
module qmon_sva #(
  parameter int NUM_CH = 32,
  parameter int CTR_W  = 32
) (
  input logic                     clk,
  input logic                     rst_ns,
  input logic                     ev_valid,
  input logic                     evt_valid,
  input logic [NUM_CH-1:0]        ctl_we,
  input logic [NUM_CH-1:0][2:0]   ch_mode,
  input logic [NUM_CH-1:0][31:0]  ch_lo,
  input logic [NUM_CH-1:0][31:0]  ch_hi
);
  localparam logic [31:0] CMAX = 32'((64'd1 << CTR_W) - 64'd1);

  p_evt_follows_op_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    evt_valid |-> $past(ev_valid));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    p_stat_sat_r8: assert property (@(posedge clk) disable iff (!rst_ns)
      (ch_mode[g] == 3'd1) |-> (ch_lo[g] <= CMAX) && (ch_hi[g] <= CMAX));

    p_stat_no_drop_r2: assert property (@(posedge clk) disable iff (!rst_ns)
      (ch_mode[g] == 3'd1) && !ctl_we[g] |=> (ch_lo[g] >= $past(ch_lo[g])));

    p_wm_order_r5: assert property (@(posedge clk) disable iff (!rst_ns)
      (ch_mode[g] == 3'd3) && (ch_lo[g] != 32'hFFFF_FFFF) |-> (ch_lo[g] <= ch_hi[g]));

    p_starve_hi_zero_r7: assert property (@(posedge clk) disable iff (!rst_ns)
      (ch_mode[g] == 3'd4) |-> (ch_hi[g] == 32'd0) && (ch_lo[g] <= CMAX));

    p_ctl_init_r9: assert property (@(posedge clk) disable iff (!rst_ns)
      ctl_we[g] |=> (ch_hi[g] == 32'd0) &&
                    (ch_lo[g] == ((ch_mode[g] == 3'd3) ? 32'hFFFF_FFFF : 32'd0)));
  end
endmodule

bind qmon_top qmon_sva #(.NUM_CH(NUM_CH), .CTR_W(CTR_W)) u_sva (
  .clk      (clk),
  .rst_ns   (rst_ns),
  .ev_valid (ev_valid),
  .evt_valid(evt_valid),
  .ctl_we   (ctl_we),
  .ch_mode  (ch_mode),
  .ch_lo    (ch_lo),
  .ch_hi    (ch_hi)
);

// File: tb/qmon_top_tb.sv
module qmon_top_tb;
  localparam int NCH = 4;
  localparam int CW  = 4;
  localparam int KW  = 8;
  localparam logic [31:0] CMAX = 32'((1 << CW) - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [16:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          ev_valid = 1'b0;
  logic          ev_push = 1'b0;
  logic [15:0]   ev_queue = '0;
  logic [KW-1:0] ev_count = '0;
  logic          evt_valid;
  logic [15:0]   evt_num;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  qmon_top #(.NUM_CH(NCH), .CTR_W(CW), .COUNT_W(KW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
    .ev_push(ev_push), .ev_queue(ev_queue), .ev_count(ev_count),
    .evt_valid(evt_valid), .evt_num(evt_num)
  );

  function automatic logic [16:0] ad(input int ch, input int w);
    return 17'(ch * 32'h1000 + w * 4);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int w, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ad(ch, w); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input int w, output logic [31:0] d);
    @(negedge clk);
    reg_addr = ad(ch, w);
    #1 d = reg_rdata;
  endtask

  task automatic op(input bit push, input int q, input int c, output logic v, output logic [15:0] n);
    @(negedge clk);
    ev_valid = 1'b1; ev_push = push; ev_queue = 16'(q); ev_count = KW'(c);
    @(negedge clk);
    v = evt_valid; n = evt_num;
    ev_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic        v;
    logic [15:0] n;
    int          lo_m, hi_m, c, evt_seen;
    bit          ins;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state of every word in every channel
    for (int ch = 0; ch < NCH; ch++) begin
      rd(ch, 0, r); check("R1 ctl", r, 32'hFFFF_0000);
      rd(ch, 1, r); check("R1 qsel", r, 32'd0);
      rd(ch, 2, r); check("R1 d0", r, 32'd0);
      rd(ch, 3, r); check("R1 d1", r, 32'd0);
    end
    check("R1 evt_valid", 32'(evt_valid), 32'd0);

    // R11 address map and reserved bits
    wr(1, 0, 32'h1234_F0F9);
    rd(1, 0, r); check("R11 ctl reserved bits", r, 32'h1234_0001);
    wr(2, 1, 32'hDEAD_0005);
    rd(2, 1, r); check("R11 qsel upper half", r, 32'h0000_0005);
    rd(3, 1, r); check("R11 neighbour untouched", r, 32'd0);

    // R2/R3 setup: ch0 stats on q5, ch1 stats but source 1, ch3 reserved mode 5
    wr(0, 0, 32'h0010_0001); wr(0, 1, 32'd5);
    wr(1, 0, 32'h0000_0101); wr(1, 1, 32'd5);
    wr(3, 0, 32'h0000_0005); wr(3, 1, 32'd5);
    evt_seen = 0;
    for (int i = 0; i < 10; i++) begin
      op(i < 7, 5, i, v, n); evt_seen += int'(v);
      op(1'b1, 6, i, v, n);  evt_seen += int'(v);
    end
    rd(0, 2, r); check("R2 push count", r, 32'd7);
    rd(0, 3, r); check("R2 pop count", r, 32'd3);
    check("R6 no event outside threshold mode", 32'(evt_seen), 32'd0);
    rd(1, 2, r); check("R3 nonzero source ignored", r, 32'd0);
    rd(3, 2, r); check("R3 reserved mode ignored", r, 32'd0);
    wr(0, 2, 32'd99);
    rd(0, 2, r); check("R2 data write ignored", r, 32'd7);

    // R8 push/pop saturation
    for (int i = 0; i < 20; i++) begin
      op(1'b1, 5, 1, v, n);
      op(1'b0, 5, 1, v, n);
    end
    rd(0, 2, r); check("R8 push saturates", r, CMAX);
    rd(0, 3, r); check("R8 pop saturates", r, CMAX);

    // R9 control rewrite clears
    wr(0, 0, 32'h0010_0001);
    rd(0, 2, r); check("R9 clear d0", r, 32'd0);
    rd(0, 3, r); check("R9 clear d1", r, 32'd0);

    // R4 thresholds, R6 crossing sweep on ch2 / q7
    wr(2, 0, 32'h0A5A_0002); wr(2, 1, 32'd7);
    wr(2, 2, 32'd3); wr(2, 3, 32'd10);
    rd(2, 2, r); check("R4 low threshold", r, 32'd3);
    rd(2, 3, r); check("R4 high threshold", r, 32'd10);
    ins = 1'b1;
    for (int k = 0; k < 32; k++) begin
      bit nin, efire;
      c = (k < 16) ? k : 31 - k;
      nin = (c >= 3) && (c <= 10);
      efire = ins && !nin;
      ins = nin;
      op(1'b1, 7, c, v, n);
      check($sformatf("R6 pulse at count %0d", c), 32'(v), 32'(efire));
      if (efire) check("R6 event number", 32'(n), 32'h0A5A);
    end
    @(negedge clk);
    check("R6 pulse one cycle", 32'(evt_valid), 32'd0);

    // R10 priority: ch2 and ch3 both fire, then ch3 alone
    wr(3, 0, 32'h0333_0002); wr(3, 1, 32'd7);
    wr(3, 2, 32'd3); wr(3, 3, 32'd10);
    wr(2, 0, 32'h0A5A_0002);
    wr(2, 2, 32'd3); wr(2, 3, 32'd10);
    op(1'b1, 7, 20, v, n);
    check("R10 both fire valid", 32'(v), 32'd1);
    check("R10 lowest index wins", 32'(n), 32'h0A5A);
    wr(2, 0, 32'h0A5A_0000);
    op(1'b1, 7, 5, v, n);
    op(1'b1, 7, 20, v, n);
    check("R10 single fire valid", 32'(v), 32'd1);
    check("R10 single fire number", 32'(n), 32'h0333);

    // R5 watermark sweep on ch1 / q9
    wr(1, 0, 32'h0000_0003); wr(1, 1, 32'd9);
    rd(1, 2, r); check("R9 wm low init", r, 32'hFFFF_FFFF);
    rd(1, 3, r); check("R9 wm high init", r, 32'd0);
    lo_m = 255; hi_m = 0;
    for (int i = 0; i < 30; i++) begin
      c = (i * 37 + 11) % 200 + 20;
      if (c < lo_m) lo_m = c;
      if (c > hi_m) hi_m = c;
      op(i[0], 9, c, v, n);
      op(1'b1, 8, 1, v, n);
    end
    rd(1, 2, r); check("R5 low watermark", r, 32'(lo_m));
    rd(1, 3, r); check("R5 high watermark", r, 32'(hi_m));
    wr(1, 3, 32'd1);
    rd(1, 3, r); check("R4 write ignored in mode 3", r, 32'(hi_m));

    // R7 starvation on ch0 / q5
    wr(0, 0, 32'h0010_0004);
    for (int i = 0; i < 3; i++) op(1'b0, 5, 0, v, n);
    for (int i = 0; i < 2; i++) op(1'b0, 5, 2, v, n);
    for (int i = 0; i < 2; i++) op(1'b1, 5, 0, v, n);
    rd(0, 2, r); check("R7 starvation count", r, 32'd3);
    rd(0, 3, r); check("R7 data1 zero", r, 32'd0);
    wr(0, 3, 32'd44);
    rd(0, 3, r); check("R4 write ignored in mode 4", r, 32'd0);
    for (int i = 0; i < 20; i++) op(1'b0, 5, 0, v, n);
    rd(0, 2, r); check("R8 starvation saturates", r, CMAX);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule